// File: doc/BRIEF.md
# Capture Row to Byte Serializer

This block sits between the sample buffer of a logic capture unit and a byte-wide serial transmitter. It takes one buffer row at a time. A row holds a sample word of `DATA_W` channel bits, an 8-bit tick count and a flag that tells whether the row was recorded before or after the trigger. The block turns that row into a framed run of bytes. The frame opens with a header byte that encodes the flag. The sample bytes follow, and the tick count closes the frame.

Both sides of the block use a full handshake. Upstream, a row moves on a cycle where `row_valid` and `row_ready` are both high. Downstream, every byte is announced by a one-cycle `tx_start`. The block then holds that byte until the transmitter pulses `tx_done`, so the pace of the serial link sets the pace of the whole stream. The block does not generate bit timing on the line.

Top module: `row_byte_serializer`

## Requirements
- R1: The first byte of every frame is 0xA1 when the row was accepted with `row_post` = 0 (before trigger) and 0xA3 when it was accepted with `row_post` = 1 (after trigger).
- R2: After the header come `DATA_W`/8 sample bytes, least significant first: byte 1 is `row_data[7:0]`, byte 2 is `row_data[15:8]`, and so on. `DATA_W` must be a nonzero multiple of 8, which is checked at elaboration.
- R3: The last byte of every frame, byte `DATA_W`/8+1, is the `row_ts` value captured with the row.
- R4: `row_ready` is high only while the block is idle. It stays low from the cycle after a row is accepted until the frame's last byte completes, so `row_valid` has no effect during that time.
- R5: `tx_start` is high for exactly one cycle per byte. The next `tx_start` comes only after a `tx_done` for the current byte, and `tx_byte` holds steady from a byte's `tx_start` until its `tx_done`.
- R6: The header's `tx_start` rises in the cycle right after the row is accepted. Each later `tx_start` rises in the cycle right after the previous byte's `tx_done`. `row_ready` returns in the cycle right after the last byte's `tx_done`.
- R7: While `rst_n` is low, and in the first cycle after it is released, the block is idle: `row_ready` = 1 and `tx_start` = 0. A frame that was in flight is dropped, and the next accepted row starts a fresh frame with its header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_valid | input | 1 | A row is offered upstream |
| row_ready | output | 1 | The block can take a row |
| row_data | input | DATA_W | Sample word of the row |
| row_ts | input | 8 | Tick count of the row (1 to 255) |
| row_post | input | 1 | 1 = row captured after the trigger |
| tx_byte | output | 8 | Byte offered to the transmitter |
| tx_start | output | 1 | One-cycle strobe: start sending `tx_byte` |
| tx_done | input | 1 | One-cycle pulse from the transmitter: current byte sent |

## Verification
The assertions assume that the transmitter raises `tx_done` only for a byte that has already been started. They also assume that `tx_done` is a single-cycle pulse and never arrives in the same cycle as `tx_start`. The bench's transmitter model keeps to this. It waits at least one cycle after each observed strobe and then pulses done for one cycle, with a gap that varies from row to row. The assertions do not depend on the tick count being in the range 1 to 255, but the stimulus keeps it there, including both ends. The stimulus drives the row fields only while offering a row, and it puts a reset in the middle of a frame.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
   localparam logic [7:0] HDR_PRE  = 8'hA1;
   localparam logic [7:0] HDR_POST = 8'hA3;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_START = 2'd1,
      ST_WAIT  = 2'd2
   } seq_state_t;
endpackage

// File: rtl/rbs_byte_mux.sv
module rbs_byte_mux #(
   parameter int DATA_W    = 16,
   parameter bit LSB_FIRST = 1'b1,
   localparam int NDATA    = DATA_W / 8,
   localparam int NBYTES   = NDATA + 2,
   localparam int IDX_W    = $clog2(NBYTES)
) (
   input  logic [DATA_W-1:0] data,
   input  logic [7:0]        ts,
   input  logic              post,
   input  logic [IDX_W-1:0]  idx,
   output logic [7:0]        byte_o
);
   import rbs_pkg::*;

   logic [7:0] lane [NDATA];

   for (genvar g = 0; g < NDATA; g++) begin : g_lane
      if (LSB_FIRST) begin : g_lsb
         assign lane[g] = data[8*g +: 8];
      end else begin : g_msb
         assign lane[g] = data[8*(NDATA-1-g) +: 8];
      end
   end

   always_comb begin
      byte_o = ts;
      if (idx == '0) begin
         byte_o = post ? HDR_POST : HDR_PRE;
      end else begin
         for (int k = 0; k < NDATA; k++) begin
            if (idx == IDX_W'(k + 1)) byte_o = lane[k];
         end
      end
   end
endmodule

// File: rtl/rbs_seq.sv
module rbs_seq #(
   parameter int NBYTES = 4,
   localparam int IDX_W = $clog2(NBYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  logic             tx_done,
   output logic             busy,
   output logic             tx_start,
   output logic [IDX_W-1:0] idx
);
   import rbs_pkg::*;

   localparam logic [IDX_W-1:0] LAST = IDX_W'(NBYTES - 1);

   seq_state_t state;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         idx   <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (fire) begin
                  state <= ST_START;
                  idx   <= '0;
               end
            end
            ST_START: state <= ST_WAIT;
            ST_WAIT: begin
               if (tx_done) begin
                  if (idx == LAST) begin
                     state <= ST_IDLE;
                  end else begin
                     idx   <= idx + 1'b1;
                     state <= ST_START;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (state != ST_IDLE);
   assign tx_start = (state == ST_START);

   assert_one_cycle_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |=> !tx_start);

   assert_accept_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && $past(rst_n)) |=> tx_start);

   assert_release_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_done && busy && !tx_start && idx == LAST) |=> !busy);

   assert_no_start_without_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tx_start && !tx_done) |=> !tx_start);
endmodule

// File: rtl/row_byte_serializer.sv
module row_byte_serializer #(
   parameter int DATA_W    = 16,
   parameter bit LSB_FIRST = 1'b1,
   localparam int NDATA    = DATA_W / 8,
   localparam int NBYTES   = NDATA + 2,
   localparam int IDX_W    = $clog2(NBYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              row_valid,
   output logic              row_ready,
   input  logic [DATA_W-1:0] row_data,
   input  logic [7:0]        row_ts,
   input  logic              row_post,
   output logic [7:0]        tx_byte,
   output logic              tx_start,
   input  logic              tx_done
);
   import rbs_pkg::*;

   if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_width
      $error("row_byte_serializer: DATA_W must be a nonzero multiple of 8");
   end

   logic              busy;
   logic              fire;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] held_data;
   logic [7:0]        held_ts;
   logic              held_post;

   assign row_ready = !busy;
   assign fire      = row_valid && row_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_data <= '0;
         held_ts   <= '0;
         held_post <= 1'b0;
      end else if (fire) begin
         held_data <= row_data;
         held_ts   <= row_ts;
         held_post <= row_post;
      end
   end

   rbs_seq #(.NBYTES(NBYTES)) seq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (fire),
      .tx_done  (tx_done),
      .busy     (busy),
      .tx_start (tx_start),
      .idx      (idx)
   );

   rbs_byte_mux #(.DATA_W(DATA_W), .LSB_FIRST(LSB_FIRST)) mux_i (
      .data   (held_data),
      .ts     (held_ts),
      .post   (held_post),
      .idx    (idx),
      .byte_o (tx_byte)
   );

   assert_header_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(row_valid && row_ready)) |->
         (tx_byte == ($past(row_post) ? HDR_POST : HDR_PRE)));

   assert_ready_only_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |-> !row_ready);

   assert_byte_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!row_ready && !tx_start && !tx_done) |=> $stable(tx_byte));
endmodule

// File: tb/row_byte_serializer_tb_top.sv
module row_byte_serializer_tb_top;
   localparam int DATA_W = 16;
   localparam int NDATA  = DATA_W / 8;
   localparam int NBYTES = NDATA + 2;
   localparam int NVEC   = 6;

   // vector layout: {post, data[15:0], ts[7:0], gap[2:0]}
   localparam logic [27:0] VEC [NVEC] = '{
      {1'b0, 16'h1234, 8'h01, 3'd0},
      {1'b1, 16'hBEEF, 8'hFF, 3'd3},
      {1'b0, 16'h00FF, 8'h80, 3'd1},
      {1'b1, 16'hA55A, 8'h02, 3'd5},
      {1'b1, 16'h0000, 8'h7F, 3'd0},
      {1'b0, 16'hFFFF, 8'hC3, 3'd2}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              row_valid = 1'b0;
   logic              row_ready;
   logic [DATA_W-1:0] row_data = '0;
   logic [7:0]        row_ts = '0;
   logic              row_post = 1'b0;
   logic [7:0]        tx_byte;
   logic              tx_start;
   logic              tx_done = 1'b0;

   int n_checks = 0;
   int n_fail   = 0;

   always #5 clk = ~clk;

   row_byte_serializer #(.DATA_W(DATA_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .row_valid(row_valid), .row_ready(row_ready),
      .row_data(row_data), .row_ts(row_ts), .row_post(row_post),
      .tx_byte(tx_byte), .tx_start(tx_start), .tx_done(tx_done)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] expect_byte(input int k, input logic post,
                                              input logic [15:0] d, input logic [7:0] ts);
      if (k == 0) return post ? 8'hA3 : 8'hA1;
      if (k == NBYTES - 1) return ts;
      return d[8*(k-1) +: 8];
   endfunction

   function automatic string req_of(input int k);
      if (k == 0) return "R1";
      if (k == NBYTES - 1) return "R3";
      return "R2";
   endfunction

   task automatic offer(input logic post, input logic [15:0] d, input logic [7:0] ts);
      @(negedge clk);
      check("R4 ready before offer", {15'd0, row_ready}, 16'd1);
      row_valid = 1'b1; row_post = post; row_data = d; row_ts = ts;
      @(negedge clk);
      row_valid = 1'b0; row_data = ~d; row_ts = ~ts; row_post = ~post;
   endtask

   // serves one byte: tx_start must be high at this negedge
   task automatic serve_byte(input int k, input int gap, input logic post,
                             input logic [15:0] d, input logic [7:0] ts);
      logic [7:0] first;
      check("R6 start on time", {15'd0, tx_start}, 16'd1);
      check("R4 ready low in frame", {15'd0, row_ready}, 16'd0);
      check(req_of(k), {8'd0, tx_byte}, {8'd0, expect_byte(k, post, d, ts)});
      first = tx_byte;
      for (int w = 0; w < gap + 1; w++) begin
         @(negedge clk);
         check("R5 no restart before done", {15'd0, tx_start}, 16'd0);
         check("R5 byte held", {8'd0, tx_byte}, {8'd0, first});
      end
      tx_done = 1'b1;
      @(negedge clk);
      tx_done = 1'b0;
   endtask

   task automatic run_row(input logic post, input logic [15:0] d,
                          input logic [7:0] ts, input int gap);
      offer(post, d, ts);
      for (int k = 0; k < NBYTES; k++) serve_byte(k, gap, post, d, ts);
      check("R6 ready after last done", {15'd0, row_ready}, 16'd1);
      check("R6 no extra start", {15'd0, tx_start}, 16'd0);
   endtask

   initial begin : watchdog
      #2_000_000;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      check("R7 ready in reset", {15'd0, row_ready}, 16'd1);
      check("R7 no start in reset", {15'd0, tx_start}, 16'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R7 idle after reset", {15'd0, row_ready}, 16'd1);

      for (int v = 0; v < NVEC; v++) begin
         run_row(VEC[v][27], VEC[v][26:11], VEC[v][10:3], int'(VEC[v][2:0]));
      end

      // R4: valid held while busy is not taken as a second row
      offer(1'b1, 16'h5AA5, 8'h10);
      row_valid = 1'b1; row_data = 16'h0F0F; row_ts = 8'h20; row_post = 1'b0;
      for (int k = 0; k < NBYTES; k++) serve_byte(k, 1, 1'b1, 16'h5AA5, 8'h10);
      row_valid = 1'b0;
      check("R4 ready after ignored offer", {15'd0, row_ready}, 16'd1);

      // R7: reset in the middle of a frame
      offer(1'b0, 16'hCAFE, 8'h33);
      serve_byte(0, 0, 1'b0, 16'hCAFE, 8'h33);
      serve_byte(1, 0, 1'b0, 16'hCAFE, 8'h33);
      rst_n = 1'b0;
      @(negedge clk);
      check("R7 mid-frame reset ready", {15'd0, row_ready}, 16'd1);
      check("R7 mid-frame reset start", {15'd0, tx_start}, 16'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R7 idle after release", {15'd0, row_ready}, 16'd1);
      check("R7 no start after release", {15'd0, tx_start}, 16'd0);
      run_row(1'b1, 16'h8001, 8'h01, 2);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule